// File: doc/BRIEF.md
# Sixteen-Bit ALU with Status Flags

This block is the arithmetic and logic core of a small 16-bit processor datapath. A two-bit operation class picks one of three engines: an add/subtract/compare unit, a logic unit with three functions, and a shifter that moves left or right depending on the sign of its shift amount. The result is combinational and leaves the block in the same cycle that its operands arrive.

Five status flags are formed from the two operands: equality, unsigned less-than, signed less-than, carry and signed overflow. They are captured in a status register only on a clock edge where the status-write enable is high. A synchronous clear empties that register. Operand selection, the register file, memory and sequencing all sit outside the block.

Top module: `alu_status_unit`

## Requirements
- R1: With opClass 00 and cmpMode 0, result is aIn+bIn+carryIn (mod 2^16) when addMode is 1 and aIn-bIn+carryIn (mod 2^16) when addMode is 0.
- R2: With opClass 01, logicSel selects the result: 00 gives aIn OR bIn, 01 gives aIn XOR bIn, 10 gives aIn AND bIn, 11 gives zero.
- R3: With opClass 10 or 11 (the two codes behave the same), the shift amount is a signed 5-bit value; a positive amount k shifts aIn left by k with zero fill, and an amount of zero returns aIn unchanged.
- R4: A negative shift amount -k (k from 1 to 16) shifts aIn right by k, filling with zeros when arithShift is 0 and with copies of aIn[15] when arithShift is 1.
- R5: The shift amount is taken from bIn[4:0] when useImm is 0 and from immIn[4:0] when useImm is 1.
- R6: With opClass 00 and cmpMode 1, result is zero and the flags come from aIn-bIn, whatever addMode and carryIn are.
- R7: On a clock edge with wrStatus 1 and clr 0, zeroFlag takes (aIn==bIn), ltuFlag takes unsigned aIn<bIn and ltsFlag takes signed aIn<bIn; the new values appear after that edge.
- R8: On such an edge with opClass 00, carryFlag takes the carry out of the 16-bit sum (for subtraction, aIn + ~bIn + 1 + carryIn, so 1 means no borrow) and ovfFlag takes signed overflow of the same sum; with any other opClass both are stored as 0.
- R9: On a clock edge with wrStatus 0 and clr 0, all five flags keep their values.
- R10: On a clock edge with clr 1, all five flags become 0, whatever wrStatus is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| clr | input | 1 | Synchronous clear of the flags |
| wrStatus | input | 1 | Status register write enable |
| opClass | input | 2 | Operation class: 00 arith/compare, 01 logic, 10/11 shift |
| logicSel | input | 2 | Logic function: 00 OR, 01 XOR, 10 AND, 11 zero |
| addMode | input | 1 | 1 add, 0 subtract |
| carryIn | input | 1 | Extra one added to the arithmetic result |
| cmpMode | input | 1 | Compare: forces subtract, zero result |
| arithShift | input | 1 | 0 zero-fill, 1 sign-fill on right shifts |
| useImm | input | 1 | Shift amount source: 0 bIn, 1 immIn |
| aIn | input | 16 | First operand |
| bIn | input | 16 | Second operand |
| immIn | input | 16 | Immediate operand for shift amounts |
| result | output | 16 | Combinational result |
| zeroFlag | output | 1 | Registered equality flag |
| ltuFlag | output | 1 | Registered unsigned less-than flag |
| ltsFlag | output | 1 | Registered signed less-than flag |
| ovfFlag | output | 1 | Registered signed overflow flag |
| carryFlag | output | 1 | Registered carry flag |

## Verification
A wrong decode of the operation class or logic code shows at result in the same cycle as the operands, so every vector compares result before the next edge. The only internal state is the five-bit status register; a wrong capture, a missed hold or a clear that loses to the write shows on the flag pins one edge after the stimulus, and the bench checks each flag bit right after that edge against its own model of the register. Shift direction and fill errors are caught at the extremes of the signed amount range, from +15 to -16.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int DataW = 16;
  localparam int AmtW  = 5;
  localparam int WideW = DataW + 2;

  typedef enum logic [1:0] {
    LogicOr   = 2'b00,
    LogicXor  = 2'b01,
    LogicAnd  = 2'b10,
    LogicNone = 2'b11
  } logicFn_e;

  // strobes sent from the decoder to the datapath
  typedef struct packed {
    logic     selArith;
    logic     selLogic;
    logic     selShift;
    logic     invertB;
    logic     extraOne;
    logic     zeroResult;
    logic     signFill;
    logic     shiftFromImm;
    logicFn_e logicFn;
  } aluCtrl_t;

  typedef struct packed {
    logic zero;
    logic ltu;
    logic lts;
    logic ovf;
    logic carry;
  } aluFlags_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [1:0] opClass,
  input  logic [1:0] logicSel,
  input  logic       addMode,
  input  logic       carryIn,
  input  logic       cmpMode,
  input  logic       arithShift,
  input  logic       useImm,
  output aluCtrl_t   ctrl
);

  logic isArith;
  logic isCompare;

  always_comb begin
    isArith   = (opClass == 2'b00);
    isCompare = isArith && cmpMode;

    ctrl.selArith     = isArith;
    ctrl.selLogic     = (opClass == 2'b01);
    ctrl.selShift     = opClass[1];
    // compare always subtracts and ignores the carry input
    ctrl.invertB      = isCompare || !addMode;
    ctrl.extraOne     = carryIn && !isCompare;
    ctrl.zeroResult   = isCompare;
    ctrl.signFill     = arithShift;
    ctrl.shiftFromImm = useImm;
    ctrl.logicFn      = logicFn_e'(logicSel);
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
(
  input  logic             clk,
  input  logic             clr,
  input  logic             wrStatus,
  input  aluCtrl_t         ctrl,
  input  logic [DataW-1:0] aIn,
  input  logic [DataW-1:0] bIn,
  input  logic [DataW-1:0] immIn,
  output logic [DataW-1:0] result,
  output aluFlags_t        flags
);

  localparam int MagW = AmtW;

  // arithmetic unit
  logic [DataW-1:0] bOp;
  logic [WideW-1:0] uSum;
  logic [WideW-1:0] sSum;
  logic [WideW-1:0] sA;
  logic [WideW-1:0] sB;
  logic             carryRaw;
  logic             ovfRaw;

  always_comb begin
    bOp  = ctrl.invertB ? ~bIn : bIn;
    uSum = {2'b00, aIn} + {2'b00, bOp}
         + {{(WideW-1){1'b0}}, ctrl.invertB}
         + {{(WideW-1){1'b0}}, ctrl.extraOne};
    carryRaw = |uSum[WideW-1:DataW];
    sA   = {{2{aIn[DataW-1]}}, aIn};
    sB   = {{2{bIn[DataW-1]}}, bIn};
    sSum = ctrl.invertB ? (sA - sB) : (sA + sB);
    sSum = sSum + {{(WideW-1){1'b0}}, ctrl.extraOne};
    ovfRaw = !((sSum[WideW-1] == sSum[WideW-2]) && (sSum[WideW-2] == sSum[DataW-1]));
  end

  // logic unit
  logic [DataW-1:0] logicRes;

  always_comb begin
    case (ctrl.logicFn)
      LogicOr:  logicRes = aIn | bIn;
      LogicXor: logicRes = aIn ^ bIn;
      LogicAnd: logicRes = aIn & bIn;
      default:  logicRes = '0;
    endcase
  end

  // bidirectional shifter, direction from the sign of the amount
  logic [AmtW-1:0]  amt;
  logic             goRight;
  logic [MagW-1:0]  mag;
  logic [DataW-1:0] shiftRes;

  always_comb begin
    amt     = ctrl.shiftFromImm ? immIn[AmtW-1:0] : bIn[AmtW-1:0];
    goRight = amt[AmtW-1];
    mag     = goRight ? (~amt + {{(AmtW-1){1'b0}}, 1'b1}) : amt;
    if (!goRight)
      shiftRes = aIn << mag;
    else if (ctrl.signFill)
      shiftRes = DataW'($signed(aIn) >>> mag);
    else
      shiftRes = aIn >> mag;
  end

  // result select
  always_comb begin
    if (ctrl.selShift)
      result = shiftRes;
    else if (ctrl.selLogic)
      result = logicRes;
    else if (ctrl.zeroResult)
      result = '0;
    else
      result = uSum[DataW-1:0];
  end

  // status register
  aluFlags_t nextFlags;

  always_comb begin
    nextFlags.zero  = (aIn == bIn);
    nextFlags.ltu   = (aIn < bIn);
    nextFlags.lts   = ($signed(aIn) < $signed(bIn));
    nextFlags.ovf   = ctrl.selArith && ovfRaw;
    nextFlags.carry = ctrl.selArith && carryRaw;
  end

  always_ff @(posedge clk) begin
    if (clr)
      flags <= '0;
    else if (wrStatus)
      flags <= nextFlags;
  end

  // R9
  hold_flags_chk: assert property (@(posedge clk) disable iff (clr)
    !wrStatus |=> $stable(flags));

  // R10
  clear_flags_chk: assert property (@(posedge clk)
    clr |=> (flags == '0));

  // R7
  eq_excl_chk: assert property (@(posedge clk) disable iff (clr)
    wrStatus |=> !(flags.zero && (flags.ltu || flags.lts)));

  // R8
  nonarith_cf_chk: assert property (@(posedge clk) disable iff (clr)
    (wrStatus && !ctrl.selArith) |=> (!flags.carry && !flags.ovf));

  // R6
  cmp_zero_chk: assert property (@(posedge clk) disable iff (clr)
    ctrl.zeroResult |-> (result == '0));

  // R2
  logic_undef_chk: assert property (@(posedge clk) disable iff (clr)
    (ctrl.selLogic && ctrl.logicFn == LogicNone) |-> (result == '0));

  // R3
  shift_pass_chk: assert property (@(posedge clk) disable iff (clr)
    (ctrl.selShift && amt == '0) |-> (result == aIn));

endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
  import alu_pkg::*;
(
  input  logic        clk,
  input  logic        clr,
  input  logic        wrStatus,
  input  logic [1:0]  opClass,
  input  logic [1:0]  logicSel,
  input  logic        addMode,
  input  logic        carryIn,
  input  logic        cmpMode,
  input  logic        arithShift,
  input  logic        useImm,
  input  logic [15:0] aIn,
  input  logic [15:0] bIn,
  input  logic [15:0] immIn,
  output logic [15:0] result,
  output logic        zeroFlag,
  output logic        ltuFlag,
  output logic        ltsFlag,
  output logic        ovfFlag,
  output logic        carryFlag
);

  aluCtrl_t  ctrl;
  aluFlags_t flags;

  alu_ctrl ctrl_i (
    .opClass    (opClass),
    .logicSel   (logicSel),
    .addMode    (addMode),
    .carryIn    (carryIn),
    .cmpMode    (cmpMode),
    .arithShift (arithShift),
    .useImm     (useImm),
    .ctrl       (ctrl)
  );

  alu_datapath dp_i (
    .clk      (clk),
    .clr      (clr),
    .wrStatus (wrStatus),
    .ctrl     (ctrl),
    .aIn      (aIn),
    .bIn      (bIn),
    .immIn    (immIn),
    .result   (result),
    .flags    (flags)
  );

  assign zeroFlag  = flags.zero;
  assign ltuFlag   = flags.ltu;
  assign ltsFlag   = flags.lts;
  assign ovfFlag   = flags.ovf;
  assign carryFlag = flags.carry;

endmodule

// File: tb/alu_status_unit_tb.sv
`timescale 1ns/1ps
module alu_status_unit_tb_top;

  logic        clk = 1'b0;
  logic        clr;
  logic        wrStatus;
  logic [1:0]  opClass;
  logic [1:0]  logicSel;
  logic        addMode, carryIn, cmpMode, arithShift, useImm;
  logic [15:0] aIn, bIn, immIn;
  logic [15:0] result;
  logic        zeroFlag, ltuFlag, ltsFlag, ovfFlag, carryFlag;

  int checks = 0;
  int fails  = 0;
  logic [4:0] modelFlags = 5'b0;  // {zero, ltu, lts, ovf, carry}

  always #4 clk = ~clk;

  alu_status_unit dut_i (
    .clk(clk), .clr(clr), .wrStatus(wrStatus), .opClass(opClass),
    .logicSel(logicSel), .addMode(addMode), .carryIn(carryIn),
    .cmpMode(cmpMode), .arithShift(arithShift), .useImm(useImm),
    .aIn(aIn), .bIn(bIn), .immIn(immIn), .result(result),
    .zeroFlag(zeroFlag), .ltuFlag(ltuFlag), .ltsFlag(ltsFlag),
    .ovfFlag(ovfFlag), .carryFlag(carryFlag)
  );

  function automatic int sx16(input logic [15:0] v);
    return v[15] ? int'(v) - 65536 : int'(v);
  endfunction

  function automatic logic isSub();
    return (cmpMode || !addMode);
  endfunction

  function automatic int effCin();
    return (cmpMode ? 0 : int'(carryIn));
  endfunction

  function automatic logic [15:0] expShift(input logic [15:0] a, input logic [4:0] amt,
                                            input logic fill);
    logic [15:0] r;
    int sa;
    sa = amt[4] ? int'(amt) - 32 : int'(amt);
    for (int i = 0; i < 16; i++) begin
      int src;
      src = i - sa;
      if (src >= 0 && src < 16) r[i] = a[src];
      else if (src >= 16)       r[i] = fill ? a[15] : 1'b0;
      else                      r[i] = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [15:0] expResult();
    int u;
    case (opClass)
      2'b00: begin
        if (cmpMode) return 16'h0;
        u = isSub() ? int'(aIn) - int'(bIn) + effCin() : int'(aIn) + int'(bIn) + effCin();
        return 16'(u);
      end
      2'b01: case (logicSel)
               2'b00: return aIn | bIn;
               2'b01: return aIn ^ bIn;
               2'b10: return aIn & bIn;
               default: return 16'h0;
             endcase
      default: return expShift(aIn, useImm ? immIn[4:0] : bIn[4:0], arithShift);
    endcase
  endfunction

  function automatic logic [4:0] expFlags();
    logic z, lu, ls, ov, cy;
    int s, u;
    z  = (aIn == bIn);
    lu = (int'(aIn) < int'(bIn));
    ls = (sx16(aIn) < sx16(bIn));
    ov = 1'b0; cy = 1'b0;
    if (opClass == 2'b00) begin
      if (isSub()) begin
        s  = sx16(aIn) - sx16(bIn) + effCin();
        cy = (int'(aIn) - int'(bIn) + effCin()) >= 0;
      end else begin
        s  = sx16(aIn) + sx16(bIn) + effCin();
        u  = int'(aIn) + int'(bIn) + effCin();
        cy = (u >= 65536);
      end
      ov = (s > 32767) || (s < -32768);
    end
    return {z, lu, ls, ov, cy};
  endfunction

  task automatic checkRes(input string req);
    logic [15:0] e;
    e = expResult();
    checks++;
    if (result !== e) begin
      fails++;
      $display("FAIL %s result: got %h expected %h (op=%b lsel=%b a=%h b=%h imm=%h)",
               req, result, e, opClass, logicSel, aIn, bIn, immIn);
    end
  endtask

  task automatic checkFlags(input string req);
    logic [4:0] got;
    got = {zeroFlag, ltuFlag, ltsFlag, ovfFlag, carryFlag};
    checks++;
    if (got !== modelFlags) begin
      fails++;
      $display("FAIL %s flags{z,ltu,lts,ovf,c}: got %b expected %b", req, got, modelFlags);
    end
  endtask

  // drive at negedge, check result, clock it, check flags
  task automatic runVec(input string req, input logic [1:0] op, input logic [1:0] ls,
                        input logic am, input logic ci, input logic cm, input logic ash,
                        input logic ui, input logic [15:0] a, input logic [15:0] b,
                        input logic [15:0] im, input logic wr, input logic cl);
    @(negedge clk);
    opClass = op; logicSel = ls; addMode = am; carryIn = ci; cmpMode = cm;
    arithShift = ash; useImm = ui; aIn = a; bIn = b; immIn = im;
    wrStatus = wr; clr = cl;
    #1;
    checkRes(req);
    if (cl)      modelFlags = 5'b0;
    else if (wr) modelFlags = expFlags();
    @(posedge clk);
    #1;
    checkFlags(req);
  endtask

  initial begin
    int seed;
    clr = 1'b1; wrStatus = 1'b0; opClass = 2'b00; logicSel = 2'b00;
    addMode = 1'b1; carryIn = 1'b0; cmpMode = 1'b0; arithShift = 1'b0;
    useImm = 1'b0; aIn = '0; bIn = '0; immIn = '0;
    seed = 32'h5eed_0a1d;
    void'($urandom(seed));
    repeat (2) @(posedge clk);
    #1;
    modelFlags = 5'b0;
    checkFlags("R10 reset");

    // R1 add, sub, carry-in
    runVec("R1 add", 2'b00, 2'b00, 1, 0, 0, 0, 0, 16'h1234, 16'h0F0F, 16'h0, 1, 0);
    runVec("R1 sub", 2'b00, 2'b00, 0, 0, 0, 0, 0, 16'h0005, 16'h0007, 16'h0, 1, 0);
    runVec("R1 add cin", 2'b00, 2'b00, 1, 1, 0, 0, 0, 16'hFFFF, 16'h0000, 16'h0, 1, 0);
    // R8 carry / overflow corners
    runVec("R8 add ovf", 2'b00, 2'b00, 1, 0, 0, 0, 0, 16'h7FFF, 16'h0001, 16'h0, 1, 0);
    runVec("R8 add carry", 2'b00, 2'b00, 1, 0, 0, 0, 0, 16'h8000, 16'h8000, 16'h0, 1, 0);
    runVec("R8 sub noborrow", 2'b00, 2'b00, 0, 0, 0, 0, 0, 16'h0009, 16'h0009, 16'h0, 1, 0);
    runVec("R8 sub ovf", 2'b00, 2'b00, 0, 0, 0, 0, 0, 16'h8000, 16'h0001, 16'h0, 1, 0);
    runVec("R8 sub cin", 2'b00, 2'b00, 0, 1, 0, 0, 0, 16'h0003, 16'h0004, 16'h0, 1, 0);
    // R6 compare ignores addMode and carryIn
    runVec("R6 cmp", 2'b00, 2'b00, 1, 1, 1, 0, 0, 16'h8000, 16'h0001, 16'h0, 1, 0);
    runVec("R6 cmp eq", 2'b00, 2'b00, 1, 1, 1, 0, 0, 16'hABCD, 16'hABCD, 16'h0, 1, 0);
    // R7 signed vs unsigned order
    runVec("R7 lts only", 2'b01, 2'b00, 1, 0, 0, 0, 0, 16'hFFFE, 16'h0002, 16'h0, 1, 0);
    runVec("R7 ltu only", 2'b01, 2'b01, 1, 0, 0, 0, 0, 16'h0002, 16'hFFFE, 16'h0, 1, 0);
    // R2 logic functions
    runVec("R2 or", 2'b01, 2'b00, 1, 0, 0, 0, 0, 16'hF0F0, 16'h0FF0, 16'h0, 1, 0);
    runVec("R2 xor", 2'b01, 2'b01, 1, 0, 0, 0, 0, 16'hF0F0, 16'h0FF0, 16'h0, 1, 0);
    runVec("R2 and", 2'b01, 2'b10, 1, 0, 0, 0, 0, 16'hF0F0, 16'h0FF0, 16'h0, 1, 0);
    runVec("R2 undef", 2'b01, 2'b11, 1, 0, 0, 0, 0, 16'hF0F0, 16'h0FF0, 16'h0, 1, 0);
    // R3 left shifts, zero amount, class 11
    runVec("R3 left 15", 2'b10, 2'b00, 1, 0, 0, 0, 0, 16'h0003, 16'h000F, 16'h0, 1, 0);
    runVec("R3 zero amt", 2'b10, 2'b00, 1, 0, 0, 1, 0, 16'hBEEF, 16'h0020, 16'h0, 1, 0);
    runVec("R3 class11", 2'b11, 2'b00, 1, 0, 0, 0, 0, 16'h00F1, 16'h0004, 16'h0, 1, 0);
    // R4 right shifts, both fills, magnitude 16
    runVec("R4 right logical", 2'b10, 2'b00, 1, 0, 0, 0, 0, 16'h8F00, 16'h001C, 16'h0, 1, 0);
    runVec("R4 right arith", 2'b10, 2'b00, 1, 0, 0, 1, 0, 16'h8F00, 16'h001C, 16'h0, 1, 0);
    runVec("R4 right 16 arith", 2'b10, 2'b00, 1, 0, 0, 1, 0, 16'h8001, 16'h0010, 16'h0, 1, 0);
    runVec("R4 right 16 log", 2'b10, 2'b00, 1, 0, 0, 0, 0, 16'h8001, 16'h0010, 16'h0, 1, 0);
    // R5 immediate amount source
    runVec("R5 imm", 2'b10, 2'b00, 1, 0, 0, 0, 1, 16'h0101, 16'h0003, 16'h001F, 1, 0);
    runVec("R5 reg", 2'b10, 2'b00, 1, 0, 0, 0, 0, 16'h0101, 16'h0003, 16'h001F, 1, 0);
    // R9 hold with different operands
    runVec("R8 set cf", 2'b00, 2'b00, 1, 0, 0, 0, 0, 16'hFFFF, 16'hFFFF, 16'h0, 1, 0);
    runVec("R9 hold", 2'b01, 2'b00, 1, 0, 0, 0, 0, 16'h0001, 16'h0001, 16'h0, 0, 0);
    // R10 clear beats write
    runVec("R10 clr", 2'b00, 2'b00, 1, 0, 0, 0, 0, 16'h0001, 16'h0001, 16'h0, 1, 1);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      logic [15:0] ra, rb, ri;
      r  = $urandom();
      ra = 16'($urandom()); rb = 16'($urandom()); ri = 16'($urandom());
      if (r[9:8] == 2'b00) rb = ra;
      runVec("R1-rand/R7", r[1:0], r[3:2], r[4], r[5], r[6] & r[10], r[7], r[11],
             ra, rb, ri, r[12] | r[13], (r[20:16] == 5'd0));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule